// File: doc/BRIEF.md
# PCI DMA Address Translator

This block sits in a PCI host bridge and turns each inbound DMA address into a system physical address. Three programmable registers set its behaviour. The first is a window base, whose bit 0 enables the window. The second is a window mask. The third is the base address of a flat page directory. An upstream agent hands the block one address at a time over a valid/ready channel. The block then makes one of two choices. It can bypass the directory and answer with a fixed mapping. Or it can fetch one 64-bit directory entry from system memory over a strobe/response port and answer with the page frame held in that entry.

Each answer is a single-cycle pulse. It carries the page-aligned input address, the translated page address, a permission code and a fault flag. The offset mask is always 0xFFF, because translation works in 4 KiB pages. Only one request is in flight at a time. `req_ready` is high only while the block is idle, and it stays low from acceptance until the cycle after the response pulse. The response has no back-pressure, so the consumer must take `rsp_valid` when it arrives. Software programs the registers through a plain write port. Writes that arrive while a translation is in flight are dropped.

Top module: `pci_dma_xlat`

## Requirements
- R1: After reset all three registers are zero, so the window is disabled. `req_ready` is 1, and both `rsp_valid` and `mem_rd` are 0.
- R2: The low 12 bits of the request address are cleared before any decision is made. `rsp_iova` is that aligned address, and `rsp_paddr[11:0]` is always zero.
- R3: When bit 0 of the window base is 0, every request bypasses the directory. No `mem_rd` is issued, and `rsp_valid` pulses in the cycle after acceptance with `rsp_perm` = 2'b11 and `rsp_fault` = 0.
- R4: When the window is enabled, a request does a lookup only if (aligned address AND mask) equals the base with bit 0 taken as 0. Any other request bypasses as in R3.
- R5: On bypass, aligned addresses below 0xF000_0000 pass through unchanged. Addresses from 0xF000_0000 to 0xFFFF_FFFF have bits 39:32 set, so 0xF000_0000 becomes 0xFF_F000_0000. Addresses above 0xFFFF_FFFF pass through unchanged.
- R6: A lookup raises `mem_rd` for exactly one cycle, the cycle after acceptance. `mem_addr` is the directory base plus (aligned address >> 12) * 8.
- R7: `mem_rdata` is the little-endian entry word, with byte k on bits 8k+7:8k. When bit 63 of that word is 1, the response has `rsp_paddr` equal to the word with bit 63 and bits 11:0 cleared, `rsp_perm` = 2'b11 and `rsp_fault` = 0.
- R8: When bit 63 of the entry is 0, the response has `rsp_fault` = 1, `rsp_perm` = 2'b00 and `rsp_paddr` = 0. `rsp_iova` is still reported.
- R9: The block holds at most one outstanding request. `req_ready` is 0 from acceptance until the response has been sent. `rsp_valid` lasts one cycle. The block acts on `mem_rvalid` only while it waits for an entry; it ignores `mem_rvalid` at all other times. The entry may arrive in the strobe cycle or any later cycle, and `rsp_valid` follows in the cycle after `mem_rvalid`.
- R10: Register write offsets are: 0 for the window base, 1 for the mask and 2 for the directory base. A write to offset 3 has no effect. A write while a translation is in flight (`req_ready` = 0) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | 64 | PCI DMA address |
| mem_rd | output | 1 | Directory read strobe, one cycle |
| mem_addr | output | 64 | Directory entry address |
| mem_rvalid | input | 1 | Directory read data valid |
| mem_rdata | input | 64 | Directory entry word |
| rsp_valid | output | 1 | Response pulse |
| rsp_iova | output | 64 | Page-aligned input address |
| rsp_paddr | output | 64 | Translated page address |
| rsp_perm | output | 2 | 2'b00 none, 2'b11 read/write |
| rsp_fault | output | 1 | Lookup found an invalid entry |

## Verification
With the window disabled, addresses are placed on each side of the 0xF000_0000 and 0xFFFF_FFFF edges. These show the identity region, the high-window remap and the unchanged wide pass-through. With the window enabled, one set of addresses falls inside the masked window and another falls outside it; the outside set includes one inside the remapped 32-bit range. This separates a lookup from a bypass and shows that the remap still applies when the window is on. Lookups use entries with bit 63 set and clear and responses at zero and several cycles of latency, which separates a good translation from a fault. Register writes during a walk, to offset 3 and stray `mem_rvalid` pulses while idle are then shown to change nothing at the ports.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int CFG_AW = 2;

  localparam logic [CFG_AW-1:0] CFG_WIN_BASE = 2'd0;
  localparam logic [CFG_AW-1:0] CFG_WIN_MASK = 2'd1;
  localparam logic [CFG_AW-1:0] CFG_DIR_BASE = 2'd2;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RW   = 2'b11
  } perm_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } walk_st_t;

endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_mask,
  output logic [ADDR_W-1:0] dir_base
);

  logic wr_ok;
  assign wr_ok = we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_base <= '0;
      win_mask <= '0;
      dir_base <= '0;
    end else if (wr_ok) begin
      case (waddr)
        CFG_WIN_BASE: win_base <= wdata;
        CFG_WIN_MASK: win_mask <= wdata;
        CFG_DIR_BASE: dir_base <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int ENT_LOG2  = 3,
  parameter int SYS_W     = 40
) (
  input  logic [ADDR_W-1:0] page_addr,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              hit,
  output logic [ADDR_W-1:0] bypass_addr,
  output logic [ADDR_W-1:0] entry_addr
);

  localparam logic [ADDR_W-1:0] EN_BIT = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              win_en;
  logic [ADDR_W-1:0] cmp_base;
  logic [ADDR_W-1:0] page_idx;

  assign win_en   = win_base[0];
  assign cmp_base = win_base & ~EN_BIT;
  assign hit      = win_en && ((page_addr & win_mask) == cmp_base);

  assign page_idx   = page_addr >> PAGE_BITS;
  assign entry_addr = dir_base + (page_idx << ENT_LOG2);

  generate
    if (SYS_W > 32) begin : g_remap
      localparam logic [ADDR_W-1:0] HI_SET =
        {{(ADDR_W-SYS_W){1'b0}}, {(SYS_W-32){1'b1}}, 32'h0};
      logic fits32;
      logic hi_win;
      assign fits32      = (page_addr[ADDR_W-1:32] == '0);
      assign hi_win      = fits32 && (page_addr[31:28] == 4'hF);
      assign bypass_addr = hi_win ? (page_addr | HI_SET) : page_addr;
    end else begin : g_identity
      assign bypass_addr = page_addr;
    end
  endgenerate

endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] page_addr,
  input  logic              hit,
  input  logic [ADDR_W-1:0] bypass_addr,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              req_ready,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_iova,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_perm,
  output logic              rsp_fault
);

  localparam logic [ADDR_W-1:0] VALID_BIT = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] OFS_MASK  = {{(ADDR_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  walk_st_t          st;
  logic [ADDR_W-1:0] iova_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [1:0]        perm_q;
  logic              fault_q;
  logic              ent_ok;

  assign ent_ok = (mem_rdata & VALID_BIT) != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      iova_q  <= '0;
      paddr_q <= '0;
      maddr_q <= '0;
      perm_q  <= PERM_NONE;
      fault_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            iova_q <= page_addr;
            if (hit) begin
              maddr_q <= entry_addr;
              st      <= ST_FETCH;
            end else begin
              paddr_q <= bypass_addr;
              perm_q  <= PERM_RW;
              fault_q <= 1'b0;
              st      <= ST_RESP;
            end
          end
        end
        ST_FETCH, ST_WAIT: begin
          if (mem_rvalid) begin
            if (ent_ok) begin
              paddr_q <= mem_rdata & ~(VALID_BIT | OFS_MASK);
              perm_q  <= PERM_RW;
              fault_q <= 1'b0;
            end else begin
              paddr_q <= '0;
              perm_q  <= PERM_NONE;
              fault_q <= 1'b1;
            end
            st <= ST_RESP;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign mem_rd    = (st == ST_FETCH);
  assign mem_addr  = maddr_q;
  assign rsp_valid = (st == ST_RESP);
  assign rsp_iova  = iova_q;
  assign rsp_paddr = paddr_q;
  assign rsp_perm  = perm_q;
  assign rsp_fault = fault_q;

endmodule

// File: rtl/pci_dma_xlat.sv
module pci_dma_xlat
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int ENT_LOG2  = 3,
  parameter int SYS_W     = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_iova,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_perm,
  output logic              rsp_fault
);

  localparam logic [ADDR_W-1:0] OFS_MASK = {{(ADDR_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  logic [ADDR_W-1:0] page_addr;
  logic [ADDR_W-1:0] win_base, win_mask, dir_base;
  logic [ADDR_W-1:0] bypass_addr, entry_addr;
  logic              hit, busy;

  assign page_addr = req_addr & ~OFS_MASK;

  xlat_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .busy(busy), .win_base(win_base), .win_mask(win_mask), .dir_base(dir_base)
  );

  xlat_match #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENT_LOG2(ENT_LOG2), .SYS_W(SYS_W)) u_match (
    .page_addr(page_addr), .win_base(win_base), .win_mask(win_mask), .dir_base(dir_base),
    .hit(hit), .bypass_addr(bypass_addr), .entry_addr(entry_addr)
  );

  xlat_walk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .page_addr(page_addr), .hit(hit),
    .bypass_addr(bypass_addr), .entry_addr(entry_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .req_ready(req_ready), .busy(busy), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .rsp_valid(rsp_valid), .rsp_iova(rsp_iova),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_iova,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_perm,
  input logic              rsp_fault
);

  a_r2_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_iova[11:0] == 12'h0 && rsp_paddr[11:0] == 12'h0));

  a_r3_accept_makes_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid ^ mem_rd));

  a_r6_read_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  a_r7_good_entry_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_perm == 2'b11));

  a_r8_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_perm == 2'b00 && rsp_paddr == '0));

  a_r9_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_busy_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);

  a_r9_busy_during_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

bind pci_dma_xlat xlat_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd(mem_rd), .rsp_valid(rsp_valid), .rsp_iova(rsp_iova),
  .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
);

// File: tb/tb_pci_dma_xlat.sv
`timescale 1ns/1ps
module tb_pci_dma_xlat;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        mem_rd;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_iova, rsp_paddr;
  logic [1:0]  rsp_perm;
  logic        rsp_fault;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pci_dma_xlat dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  // results of the last request
  bit          r_got, r_saw_rd, r_busy_ok, r_pulse_ok;
  logic [63:0] r_rd_addr, r_iova, r_paddr;
  logic [1:0]  r_perm;
  bit          r_fault;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input logic [63:0] a, input logic [63:0] data, input int lat,
                        input bit wr_busy, input logic [1:0] wa, input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    r_saw_rd = 0; r_busy_ok = 1; r_rd_addr = '0;
    if (mem_rd) begin
      r_saw_rd  = 1;
      r_rd_addr = mem_addr;
      if (req_ready) r_busy_ok = 0;
      if (wr_busy) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        cfg_we = 1'b0;
        if (mem_rd || req_ready || rsp_valid) r_busy_ok = 0;
      end
      mem_rvalid = 1'b1; mem_rdata = data;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = '0; cfg_we = 1'b0;
    end
    r_got   = rsp_valid;
    r_iova  = rsp_iova;
    r_paddr = rsp_paddr;
    r_perm  = rsp_perm;
    r_fault = rsp_fault;
    if (req_ready) r_busy_ok = 0;
    @(negedge clk);
    r_pulse_ok = !rsp_valid && req_ready;
  endtask

  task automatic expect_bypass(input string req, input logic [63:0] a, input logic [63:0] exp_pa);
    do_req(a, '0, 0, 0, 2'd0, '0);
    chk(req, "rsp_valid", {63'b0, r_got}, 64'd1);
    chk(req, "no mem_rd", {63'b0, r_saw_rd}, 64'd0);
    chk(req, "iova", r_iova, a & ~64'hFFF);
    chk(req, "paddr", r_paddr, exp_pa);
    chk(req, "perm", {62'b0, r_perm}, 64'd3);
    chk(req, "fault", {63'b0, r_fault}, 64'd0);
  endtask

  task automatic expect_lookup(input string req, input logic [63:0] a, input logic [63:0] exp_ea,
                               input logic [63:0] data, input int lat, input logic [63:0] exp_pa,
                               input bit exp_fault);
    do_req(a, data, lat, 0, 2'd0, '0);
    chk(req, "mem_rd seen", {63'b0, r_saw_rd}, 64'd1);
    chk(req, "mem_addr", r_rd_addr, exp_ea);
    chk(req, "rsp_valid", {63'b0, r_got}, 64'd1);
    chk(req, "iova", r_iova, a & ~64'hFFF);
    chk(req, "paddr", r_paddr, exp_pa);
    chk(req, "perm", {62'b0, r_perm}, exp_fault ? 64'd0 : 64'd3);
    chk(req, "fault", {63'b0, r_fault}, {63'b0, exp_fault});
    chk("R9", "busy while walking", {63'b0, r_busy_ok}, 64'd1);
    chk("R9", "single rsp pulse", {63'b0, r_pulse_ok}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", {63'b0, req_ready}, 64'd1);
    chk("R1", "rsp_valid", {63'b0, rsp_valid}, 64'd0);
    chk("R1", "mem_rd", {63'b0, mem_rd}, 64'd0);
    expect_bypass("R1", 64'h0000_0040_0000_5678, 64'h0000_0040_0000_5000);
  endtask

  task automatic t_remap;
    expect_bypass("R5", 64'h0000_0000_1234_5678, 64'h0000_0000_1234_5000);
    expect_bypass("R5", 64'h0000_0000_EFFF_FFFF, 64'h0000_0000_EFFF_F000);
    expect_bypass("R5", 64'h0000_0000_F000_0000, 64'h0000_00FF_F000_0000);
    expect_bypass("R5", 64'h0000_0000_FFFF_FFFF, 64'h0000_00FF_FFFF_F000);
    expect_bypass("R5", 64'h0000_0001_0000_0ABC, 64'h0000_0001_0000_0000);
    expect_bypass("R2", 64'h0000_00F0_F000_0FFF, 64'h0000_00F0_F000_0000);
  endtask

  task automatic t_enable_clear;
    cfg_write(2'd1, 64'hFFFF_FFC0_0000_0000);
    cfg_write(2'd2, 64'h0000_0000_8000_0000);
    cfg_write(2'd0, 64'h0000_0040_0000_0000);
    expect_bypass("R3", 64'h0000_0040_0000_5123, 64'h0000_0040_0000_5000);
  endtask

  task automatic t_window_miss;
    cfg_write(2'd0, 64'h0000_0040_0000_0001);
    expect_bypass("R4", 64'h0000_0080_0000_1000, 64'h0000_0080_0000_1000);
    expect_bypass("R4", 64'h0000_0000_F000_0000, 64'h0000_00FF_F000_0000);
  endtask

  task automatic t_lookup_valid;
    expect_lookup("R7", 64'h0000_0040_0000_5123, 64'h0000_0000_A000_0028,
                  64'h8000_0012_3456_7ABC, 0, 64'h0000_0012_3456_7000, 0);
    expect_lookup("R6", 64'h0000_0040_0000_0000, 64'h0000_0000_A000_0000,
                  64'hFFFF_FFFF_FFFF_FFFF, 3, 64'h7FFF_FFFF_FFFF_F000, 0);
  endtask

  task automatic t_lookup_fault;
    expect_lookup("R8", 64'h0000_0040_0001_0FFF, 64'h0000_0000_A000_0080,
                  64'h7FFF_FFFF_FFFF_F000, 2, 64'h0, 1);
  endtask

  task automatic t_busy_write;
    do_req(64'h0000_0040_0000_2000, 64'h8000_0000_0000_3000, 2, 1, 2'd0, 64'h0);
    chk("R10", "walk with write", r_paddr, 64'h0000_0000_0000_3000);
    expect_lookup("R10", 64'h0000_0040_0000_2000, 64'h0000_0000_A000_0010,
                  64'h8000_0000_0000_4000, 1, 64'h0000_0000_0000_4000, 0);
    cfg_write(2'd3, 64'h0);
    expect_lookup("R10", 64'h0000_0040_0000_3000, 64'h0000_0000_A000_0018,
                  64'h8000_0000_0000_5000, 0, 64'h0000_0000_0000_5000, 0);
  endtask

  task automatic t_stray_rvalid;
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 64'h8000_0000_DEAD_B000;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R9", "no rsp from stray rvalid", {63'b0, rsp_valid}, 64'd0);
    chk("R9", "still ready", {63'b0, req_ready}, 64'd1);
    @(negedge clk);
    chk("R9", "no rsp after stray", {63'b0, rsp_valid}, 64'd0);
    expect_bypass("R9", 64'h0000_0000_0000_7000, 64'h0000_0000_0000_7000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_remap();
    t_enable_clear();
    t_window_miss();
    t_lookup_valid();
    t_lookup_fault();
    t_busy_write();
    t_stray_rvalid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule